// File: doc/BRIEF.md
# Hashing Task Queue and Result Record FIFO

This block sits between a register-bus decoder and an array of hashing cores. Hashing jobs arrive as fixed-layout 48-byte records and wait in a task queue. The cores pull them from the head of the queue. Finished work comes back from the cores as 8-byte result records. These are held in a result FIFO and read out one byte at a time. A status byte gives the number of complete records waiting, so software can drain them in one burst of eight bytes per record.

A control byte holds four flags. One stalls delivery of tasks to the cores. One is forwarded to the cores as a pause. One admits completion records that carry no nonce. One selects test mode. A flush input clears the task queue. Any write that arrives when the queue has no room is lost, and a sticky flag records the loss. The cores are represented here by a plain result-injection port that delivers a whole record in one cycle, so each record becomes visible complete and the count changes in the same cycle as the record.

Top module: `task_result_buf`

## Requirements
- R1: A queued task is presented as 384 bits with byte 0 at bits 383:376: the 16-bit task ID most significant byte first, two zero bytes, the 32-byte midstate, then the 12-byte tail. Tasks come out in write order, and `task_take_i` while `task_valid_o` is high removes the head.
- R2: The task queue holds TASK_DEPTH (16) tasks. A write that finds the queue full, with no take in the same cycle, is discarded and sets `task_ovf_o`. The flag then stays set until a flush.
- R3: `flush_i` empties the task queue and clears `task_ovf_o` on the next edge. A task write in the same cycle is discarded.
- R4: While control bit 3 is set, `task_valid_o` is low and queued tasks are kept.
- R5: Control bit 4 drives `core_pause_o` and control bit 1 drives `test_mode_o`. The control byte is loaded by `ctrl_we_i` and resets to zero.
- R6: A result record is read as bytes in this order: task ID bits 15:8, task ID bits 7:0, core ID, flags (bit 7 = no nonce, other bits zero), then the nonce least significant byte first.
- R7: An injected record with `res_no_nonce_i` set is stored only when control bit 2 is set. Otherwise it is dropped.
- R8: `res_count_o` equals the number of stored records. It rises in the cycle after an injection and falls only when the eighth byte of the head record is read. Partial reads leave it unchanged.
- R9: With no record stored, `rd_byte_o` is 0xFF and a read changes nothing.
- R10: An injection that finds the result FIFO full (RES_DEPTH records), with no record completing its readout in the same cycle, is dropped.
- R11: After reset both queues are empty, `res_count_o` is 0, `task_ovf_o` is 0 and `rd_byte_o` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Load control byte |
| ctrl_i | input | 8 | Control byte value |
| task_we_i | input | 1 | Task write strobe |
| task_id_i | input | 16 | Task ID |
| task_mid_i | input | 256 | Midstate |
| task_tail_i | input | 96 | Message tail |
| flush_i | input | 1 | Discard all queued tasks |
| task_valid_o | output | 1 | Head task available to cores |
| task_rec_o | output | 384 | Head task record |
| task_take_i | input | 1 | Core takes head task |
| task_ovf_o | output | 1 | Sticky task overflow flag |
| res_we_i | input | 1 | Result injection strobe |
| res_task_id_i | input | 16 | Result task ID |
| res_core_i | input | 8 | Reporting core ID |
| res_no_nonce_i | input | 1 | Completion without nonce |
| res_nonce_i | input | 32 | Found nonce |
| rd_i | input | 1 | Read one result byte |
| rd_byte_o | output | 8 | Current result byte |
| res_count_o | output | 8 | Complete records waiting |
| core_pause_o | output | 1 | Pause request to cores |
| test_mode_o | output | 1 | Test mode select |

## Verification
The directed patterns are chosen to separate specific faults. Filling the task queue to sixteen and then writing two more separates a depth or overflow error from an ordering error. A write at the same time as a take on a full queue shows whether full is judged before the pop. Result records with distinct bytes in every position are read in partial bursts, which exposes byte swaps in the ID or nonce and a count that drops too early. No-nonce injections with the enable bit clear and then set show the filter. A long random phase mixes pauses, flushes, takes, reads on an empty FIFO and injections into a full FIFO against a queue-based model, to catch interactions between these cases.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int TASK_W  = 384;
  localparam int RES_W   = 64;
  localparam int CB_PCORE = 4;
  localparam int CB_PQUEUE = 3;
  localparam int CB_NONONCE = 2;
  localparam int CB_TEST  = 1;
endpackage

// File: rtl/tq_fifo.sv
module tq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          rej_o
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic full, do_pop, do_push;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign rej_o   = push_i && !do_push;
  assign data_o  = mem[rp_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wp_q] <= data_i;
  end
endmodule

// File: rtl/tq_res_reader.sv
module tq_res_reader #(
  parameter int BYTES = 8,
  localparam int IW = $clog2(BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [8*BYTES-1:0] rec_i,
  input  logic             empty_i,
  input  logic             rd_i,
  output logic [7:0]       byte_o,
  output logic             pop_o
);
  logic [IW-1:0] idx_q;
  logic step, last;

  assign step  = rd_i && !empty_i;
  assign last  = (idx_q == IW'(BYTES - 1));
  assign pop_o = step && last;
  assign byte_o = empty_i ? 8'hFF : rec_i[8*(BYTES-1-int'(idx_q)) +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (step) idx_q <= last ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/task_result_buf.sv
module task_result_buf
  import tq_pkg::*;
#(
  parameter int TASK_DEPTH = 16,
  parameter int RES_DEPTH  = 16,
  localparam int TCW = $clog2(TASK_DEPTH + 1),
  localparam int RCW = $clog2(RES_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [7:0]         ctrl_i,
  input  logic               task_we_i,
  input  logic [15:0]        task_id_i,
  input  logic [255:0]       task_mid_i,
  input  logic [95:0]        task_tail_i,
  input  logic               flush_i,
  output logic               task_valid_o,
  output logic [TASK_W-1:0]  task_rec_o,
  input  logic               task_take_i,
  output logic               task_ovf_o,
  input  logic               res_we_i,
  input  logic [15:0]        res_task_id_i,
  input  logic [7:0]         res_core_i,
  input  logic               res_no_nonce_i,
  input  logic [31:0]        res_nonce_i,
  input  logic               rd_i,
  output logic [7:0]         rd_byte_o,
  output logic [7:0]         res_count_o,
  output logic               core_pause_o,
  output logic               test_mode_o
);
  logic [7:0] ctrl_q;
  logic ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_i;
  end

  assign core_pause_o = ctrl_q[CB_PCORE];
  assign test_mode_o  = ctrl_q[CB_TEST];

  // task queue
  logic [TASK_W-1:0] t_in, t_head;
  logic [TCW-1:0] t_cnt;
  logic t_empty, t_rej, t_pop;

  assign t_in  = {task_id_i, 16'h0000, task_mid_i, task_tail_i};
  assign task_valid_o = !t_empty && !ctrl_q[CB_PQUEUE];
  assign t_pop = task_take_i && task_valid_o;
  assign task_rec_o = t_head;

  tq_fifo #(.W(TASK_W), .DEPTH(TASK_DEPTH)) u_task_q (
    .clk_i, .rst_ni, .clr_i(flush_i), .push_i(task_we_i), .data_i(t_in),
    .pop_i(t_pop), .data_o(t_head), .count_o(t_cnt), .empty_o(t_empty), .rej_o(t_rej)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (flush_i) ovf_q <= 1'b0;
    else if (t_rej) ovf_q <= 1'b1;
  end
  assign task_ovf_o = ovf_q;

  // result FIFO: whole record written in one cycle, so count and data move together
  logic [RES_W-1:0] r_in, r_head;
  logic [RCW-1:0] r_cnt;
  logic r_empty, r_rej, r_pop, r_push;

  assign r_push = res_we_i && (!res_no_nonce_i || ctrl_q[CB_NONONCE]);
  assign r_in = {res_task_id_i, res_core_i, res_no_nonce_i, 7'd0,
                 res_nonce_i[7:0], res_nonce_i[15:8], res_nonce_i[23:16], res_nonce_i[31:24]};

  tq_fifo #(.W(RES_W), .DEPTH(RES_DEPTH)) u_res_q (
    .clk_i, .rst_ni, .clr_i(1'b0), .push_i(r_push), .data_i(r_in),
    .pop_i(r_pop), .data_o(r_head), .count_o(r_cnt), .empty_o(r_empty), .rej_o(r_rej)
  );

  tq_res_reader #(.BYTES(RES_W / 8)) u_rd (
    .clk_i, .rst_ni, .rec_i(r_head), .empty_i(r_empty), .rd_i,
    .byte_o(rd_byte_o), .pop_o(r_pop)
  );

  assign res_count_o = 8'(r_cnt);

  logic unused;
  assign unused = ^{t_cnt, r_rej};
endmodule

// File: rtl/task_result_buf_chk.sv
module task_result_buf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flush_i,
  input logic       task_valid_o,
  input logic       task_ovf_o,
  input logic [7:0] ctrl_q,
  input logic [7:0] res_count_o,
  input logic [7:0] rd_byte_o,
  input logic       res_we_i,
  input logic       res_no_nonce_i,
  input logic       rd_i
);
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_ovf_o && !flush_i |=> task_ovf_o); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !task_valid_o && !task_ovf_o); // R3

  AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[3] |-> !task_valid_o); // R4

  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_count_o == 8'd0 |-> rd_byte_o == 8'hFF); // R9

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (res_count_o == $past(res_count_o)) || (res_count_o == $past(res_count_o) + 8'd1)
             || (res_count_o == $past(res_count_o) - 8'd1)); // R8

  AST_NONONCE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_i && res_no_nonce_i && !ctrl_q[2] |=> res_count_o <= $past(res_count_o)); // R7

  AST_NO_READ_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> res_count_o >= $past(res_count_o)); // R8
endmodule

bind task_result_buf task_result_buf_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .task_valid_o(task_valid_o),
  .task_ovf_o(task_ovf_o), .ctrl_q(ctrl_q), .res_count_o(res_count_o),
  .rd_byte_o(rd_byte_o), .res_we_i(res_we_i), .res_no_nonce_i(res_no_nonce_i), .rd_i(rd_i)
);

// File: tb/task_result_buf_bench.sv
module task_result_buf_bench;
  localparam int TD = 16;
  localparam int RD = 16;

  logic clk_i = 0, rst_ni = 0;
  logic ctrl_we_i = 0; logic [7:0] ctrl_i = 0;
  logic task_we_i = 0; logic [15:0] task_id_i = 0;
  logic [255:0] task_mid_i = 0; logic [95:0] task_tail_i = 0;
  logic flush_i = 0, task_take_i = 0;
  logic task_valid_o, task_ovf_o; logic [383:0] task_rec_o;
  logic res_we_i = 0; logic [15:0] res_task_id_i = 0; logic [7:0] res_core_i = 0;
  logic res_no_nonce_i = 0; logic [31:0] res_nonce_i = 0; logic rd_i = 0;
  logic [7:0] rd_byte_o, res_count_o; logic core_pause_o, test_mode_o;

  always #5ns clk_i = ~clk_i;

  task_result_buf #(.TASK_DEPTH(TD), .RES_DEPTH(RD)) u_task_result_buf (.*);

  int vecs = 0, errs = 0;
  logic [383:0] m_tq[$];
  logic [63:0]  m_rq[$];
  logic m_ovf = 0; logic [7:0] m_ctrl = 0; int m_idx = 0;

  task automatic chk1(string req, string nm, logic [383:0] act, logic [383:0] exp);
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  // compare all outputs against the model; outputs depend on state only
  task automatic compare();
    logic [7:0] eb;
    vecs++;
    eb = (m_rq.size() == 0) ? 8'hFF : m_rq[0][8*(7-m_idx) +: 8];
    chk1("R4", "task_valid", 384'(task_valid_o), 384'(m_tq.size() > 0 && !m_ctrl[3]));
    if (m_tq.size() > 0) chk1("R1", "task_rec", task_rec_o, m_tq[0]);
    chk1("R2", "task_ovf", 384'(task_ovf_o), 384'(m_ovf));
    chk1("R6", "rd_byte", 384'(rd_byte_o), 384'(eb));
    chk1("R8", "res_count", 384'(res_count_o), 384'(m_rq.size()));
    chk1("R5", "core_pause", 384'(core_pause_o), 384'(m_ctrl[4]));
    chk1("R5", "test_mode", 384'(test_mode_o), 384'(m_ctrl[1]));
  endtask

  task automatic model_step();
    logic tpop, racc, rpop, rreq, tacc;
    logic [7:0] oc = m_ctrl;
    tpop = task_take_i && m_tq.size() > 0 && !oc[3];
    if (flush_i) begin m_tq.delete(); m_ovf = 0; end // R3
    else begin
      tacc = task_we_i && (m_tq.size() < TD || tpop);
      if (tpop) void'(m_tq.pop_front());
      if (tacc) m_tq.push_back({task_id_i, 16'h0, task_mid_i, task_tail_i});
      if (task_we_i && !tacc) m_ovf = 1;
    end
    rreq = res_we_i && (!res_no_nonce_i || oc[2]); // R7
    rpop = rd_i && m_rq.size() > 0 && m_idx == 7;
    racc = rreq && (m_rq.size() < RD || rpop); // R10
    if (rd_i && m_rq.size() > 0) m_idx = (m_idx == 7) ? 0 : m_idx + 1; // R9 no step when empty
    if (rpop) void'(m_rq.pop_front());
    if (racc) m_rq.push_back({res_task_id_i, res_core_i, res_no_nonce_i, 7'd0,
      res_nonce_i[7:0], res_nonce_i[15:8], res_nonce_i[23:16], res_nonce_i[31:24]});
    if (ctrl_we_i) m_ctrl = ctrl_i;
  endtask

  task automatic cyc();
    #1; compare(); model_step();
    @(posedge clk_i); #2;
    ctrl_we_i = 0; task_we_i = 0; flush_i = 0; task_take_i = 0; res_we_i = 0; rd_i = 0;
  endtask

  task automatic put_task(logic [15:0] id);
    task_we_i = 1; task_id_i = id;
    task_mid_i = {8{$urandom()}}; task_tail_i = {3{$urandom()}};
  endtask

  task automatic put_res(logic [15:0] id, logic [7:0] c, logic nn, logic [31:0] n);
    res_we_i = 1; res_task_id_i = id; res_core_i = c; res_no_nonce_i = nn; res_nonce_i = n;
  endtask

  task automatic set_ctrl(logic [7:0] v); ctrl_we_i = 1; ctrl_i = v; endtask

  bit done = 0;
  initial begin
    #2ms;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2; rst_ni = 1;
    cyc(); // R11 reset state compared
    // R2: fill to 16, then two more
    for (int i = 0; i < TD + 2; i++) begin put_task(16'h1200 + 16'(i)); cyc(); end
    // R2: write with take on a full queue is accepted
    put_task(16'hABCD); task_take_i = 1; cyc();
    // R4: pause queue, take ignored
    set_ctrl(8'h08); cyc(); task_take_i = 1; cyc(); cyc();
    set_ctrl(8'h12); cyc(); // R5
    for (int i = 0; i < 3; i++) begin task_take_i = 1; cyc(); end // R1 order
    flush_i = 1; put_task(16'h7777); cyc(); cyc(); // R3
    // R6/R8 results with distinct bytes, partial read
    put_res(16'hA1B2, 8'hC3, 0, 32'hD4E5F607); cyc();
    put_res(16'h0102, 8'h03, 0, 32'h04050607); cyc();
    for (int i = 0; i < 5; i++) begin rd_i = 1; cyc(); end
    put_res(16'h5555, 8'h01, 1, 32'h0); cyc(); // R7 dropped
    set_ctrl(8'h04); cyc();
    put_res(16'h6666, 8'h02, 1, 32'h0); cyc(); // R7 kept
    for (int i = 0; i < 20; i++) begin rd_i = 1; cyc(); end // drain, then R9 empty reads
    // R10: fill result FIFO and overflow
    for (int i = 0; i < RD + 2; i++) begin put_res(16'(i), 8'(i), 0, $urandom()); cyc(); end
    for (int i = 0; i < 7; i++) begin rd_i = 1; cyc(); end
    rd_i = 1; put_res(16'hFEED, 8'h09, 0, 32'h11223344); cyc(); // pop+push when full
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 19) == 0) set_ctrl(8'($urandom()));
      if ($urandom_range(0, 2) == 0) put_task(16'($urandom()));
      if ($urandom_range(0, 2) == 0) task_take_i = 1;
      if ($urandom_range(0, 60) == 0) flush_i = 1;
      if ($urandom_range(0, 3) == 0) put_res(16'($urandom()), 8'($urandom()), 1'($urandom()), $urandom());
      if ($urandom_range(0, 1) == 0) rd_i = 1;
      cyc();
    end
    #1; compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule